// File: doc/BRIEF.md
# Serial NOR Flash Slave with Sequential Word Programming

This block is a synthesizable model of a serial NOR flash device on an SPI bus (mode 0, most significant bit first). A byte-level command decoder sits behind a byte-wide slave shifter. The shifter runs in the system clock domain and samples the bus lines through synchronizers. The device holds a small byte array, a write-enable latch, a sequence-active flag and a current-address register. Its command set covers write enable, write disable, status read, plain read, and an auto-incrementing program sequence. In that sequence the address is sent only once, and each later sequence opcode continues programming from where the previous one stopped.

While the sequence is active, only three opcodes are accepted. The sequence ends when write disable is issued or when programming wraps past the top of the array. A one-cycle error pulse marks rejected or illegal operations. Erase commands, multi-line I/O, sector protection and busy timing are not modelled.

Top module: `spif_aai_slave`

## Requirements
- R1: After reset the write-enable latch and the sequence flag are clear, the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Opcode 0x06 sets the write-enable latch. Opcode 0x05 returns the status byte after the opcode and repeats it for as long as chip select stays low. Bit 1 of the status byte mirrors the write-enable latch.
- R3: Opcode 0x03 followed by the address bytes (most significant first) streams array bytes from that address. The address advances by one per byte, modulo the array size.
- R4: Opcode 0xAD with the write-enable latch clear produces one error pulse and leaves the latch, the flag and the array unchanged.
- R5: The first 0xAD with the latch set raises the sequence flag and collects 3 address bytes, or 4 when addr4_en is high. It then clears address bit 0 and programs the following data bytes from that even address.
- R6: A 0xAD issued while the sequence is active takes no address bytes and programs its data bytes from the current address.
- R7: While the sequence is active, any opcode other than 0xAD, 0x04 or 0x05 produces one error pulse and is not executed.
- R8: Opcode 0x04 clears the write-enable latch and ends the sequence.
- R9: Bit 6 of the status byte is set exactly while the sequence is active.
- R10: Each program byte is ANDed into the addressed array byte, and the address then advances by one. When the address wraps to zero during the sequence, both the latch and the flag clear.
- R11: A program byte that arrives with the latch clear leaves the array unchanged and produces one error pulse.
- R12: An opcode with no defined meaning produces one error pulse.
- R13: Raising chip select ends the current command. The next byte after chip select falls is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bus lines are oversampled with it |
| rst_n | input | 1 | Synchronous active-low reset |
| addr4_en | input | 1 | High selects four address bytes instead of three |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, updated after falling serial-clock edges |
| err_pulse | output | 1 | One-cycle pulse on a rejected or illegal operation |

## Verification
The hardest case to reach is the automatic abort at the top of the array. The sequence has to be started with an odd address just below the top. Its even alignment must place exactly four bytes before the wrap. A fifth byte is then sent in the same chip-select window. That fifth byte must see the latch already clear, so it leaves address zero untouched and raises an error. The bench drives this sequence and then reads the status and a window that straddles the wrap. It also holds a byte-level model of the array, which the final sweep over the whole array compares against, so every earlier AND-program leaves a trace that can be checked.

// File: rtl/spif_pkg.sv
// Shared opcodes, status bit positions and decoder phases for the flash slave.
package spif_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_SEQ  = 8'hAD;

    localparam int ST_WEL_BIT = 1;
    localparam int ST_SEQ_BIT = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PROG,
        PH_READ,
        PH_STAT,
        PH_SINK
    } phase_t;
endpackage

// File: rtl/spif_link.sv
// Byte-wide SPI mode-0 slave shifter in the system clock domain.
// Assumes the serial clock is much slower than clk (at least 4 clk per half period).
// rx_valid pulses once per received byte; tx_byte is loaded on the falling edge
// that follows each completed byte.
module spif_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       sel,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       miso
);
    logic [2:0] sclk_sync;
    logic [1:0] cs_sync;
    logic [1:0] mosi_sync;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       sclk_rise;
    logic       sclk_fall;

    assign sclk_rise = sclk_sync[1] & ~sclk_sync[2];
    assign sclk_fall = ~sclk_sync[1] & sclk_sync[2];
    assign sel       = ~cs_sync[1];
    assign miso      = tx_sh[7];

    // Synchronize the bus lines into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sync <= '0;
            cs_sync   <= 2'b11;
            mosi_sync <= '0;
        end else begin
            sclk_sync <= {sclk_sync[1:0], sclk};
            cs_sync   <= {cs_sync[0], cs_n};
            mosi_sync <= {mosi_sync[0], mosi};
        end
    end

    // Shift bits in on rising edges and out on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_valid <= 1'b0;
            if (!rst_n) rx_byte <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (sclk_rise) begin
                rx_sh   <= {rx_sh[5:0], mosi_sync[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sh, mosi_sync[1]};
                end
            end
            if (sclk_fall) begin
                if (bit_cnt == 3'd0) tx_sh <= tx_byte;
                else                 tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spif_array.sv
// Byte array with AND-only writes (bits can only be cleared) and a combinational read.
// Reset returns every byte to the erased value 0xFF.
module spif_array #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    assign rdata = mem[raddr];

    // Erase on reset, AND the write byte into the addressed cell.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)                           mem[i] <= 8'hFF;
            else if (we && waddr == AW'(i))       mem[i] <= mem[i] & wdata;
        end
    end
endmodule

// File: rtl/spif_ctrl.sv
// Command decoder: opcode dispatch, address collection, program sequencing and status.
// Assumes rx_valid pulses at most once every few cycles and sel drops between commands.
module spif_ctrl
    import spif_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          addr4_en,
    input  logic [7:0]    rd_data,
    output logic [7:0]    tx_byte,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic [AW-1:0] mem_raddr,
    output logic          err_pulse,
    output logic          wel,
    output logic          aai,
    output phase_t        phase,
    output logic [AW-1:0] cur_addr
);
    logic [31:0]   addr_acc;
    logic [1:0]    addr_left;
    logic          for_read;
    logic [31:0]   full_addr;
    logic [AW-1:0] hit_addr;
    logic [AW-1:0] next_addr;
    logic [7:0]    status;
    logic          seq_legal;

    assign full_addr = {addr_acc[23:0], rx_byte};
    assign hit_addr  = full_addr[AW-1:0];
    assign next_addr = cur_addr + AW'(1);
    assign seq_legal = (rx_byte == OP_SEQ) || (rx_byte == OP_WRDI) || (rx_byte == OP_RDSR);

    // Status byte: latch and sequence flag at their fixed positions.
    always_comb begin
        status             = 8'h00;
        status[ST_WEL_BIT] = wel;
        status[ST_SEQ_BIT] = aai;
    end

    // Array port steering: read follows the address being resolved or the cursor.
    always_comb begin
        mem_we    = rx_valid && sel && (phase == PH_PROG) && wel;
        mem_waddr = cur_addr;
        mem_wdata = rx_byte;
        mem_raddr = (phase == PH_ADDR) ? hit_addr : cur_addr;
    end

    // Decoder state machine, latch, flag and cursor updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            wel       <= 1'b0;
            aai       <= 1'b0;
            cur_addr  <= '0;
            addr_acc  <= '0;
            addr_left <= '0;
            for_read  <= 1'b0;
            tx_byte   <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= 1'b0;
            if (!sel) begin
                phase <= PH_IDLE;
            end else if (rx_valid) begin
                unique case (phase)
                    PH_IDLE: begin
                        if (aai && !seq_legal) begin
                            err_pulse <= 1'b1;
                            phase     <= PH_SINK;
                        end else begin
                            unique case (rx_byte)
                                OP_WREN: begin
                                    wel   <= 1'b1;
                                    phase <= PH_SINK;
                                end
                                OP_WRDI: begin
                                    wel   <= 1'b0;
                                    aai   <= 1'b0;
                                    phase <= PH_SINK;
                                end
                                OP_RDSR: begin
                                    tx_byte <= status;
                                    phase   <= PH_STAT;
                                end
                                OP_READ: begin
                                    addr_acc  <= '0;
                                    addr_left <= addr4_en ? 2'd3 : 2'd2;
                                    for_read  <= 1'b1;
                                    phase     <= PH_ADDR;
                                end
                                OP_SEQ: begin
                                    if (!wel) begin
                                        err_pulse <= 1'b1;
                                        phase     <= PH_SINK;
                                    end else if (aai) begin
                                        phase <= PH_PROG;
                                    end else begin
                                        aai       <= 1'b1;
                                        addr_acc  <= '0;
                                        addr_left <= addr4_en ? 2'd3 : 2'd2;
                                        for_read  <= 1'b0;
                                        phase     <= PH_ADDR;
                                    end
                                end
                                default: begin
                                    err_pulse <= 1'b1;
                                    phase     <= PH_SINK;
                                end
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        if (addr_left == 2'd0) begin
                            if (for_read) begin
                                tx_byte  <= rd_data;
                                cur_addr <= hit_addr + AW'(1);
                                phase    <= PH_READ;
                            end else begin
                                cur_addr <= hit_addr & ~AW'(1);
                                phase    <= PH_PROG;
                            end
                        end else begin
                            addr_acc  <= full_addr;
                            addr_left <= addr_left - 2'd1;
                        end
                    end
                    PH_READ: begin
                        tx_byte  <= rd_data;
                        cur_addr <= next_addr;
                    end
                    PH_STAT: begin
                        tx_byte <= status;
                    end
                    PH_PROG: begin
                        if (!wel) err_pulse <= 1'b1;
                        cur_addr <= next_addr;
                        if (aai && next_addr == '0) begin
                            wel <= 1'b0;
                            aai <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spif_aai_slave.sv
// Top level: SPI shifter, command decoder and byte array wired together.
// Assumes the host keeps the serial clock well below clk/8.
module spif_aai_slave
    import spif_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr4_en,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic err_pulse
);
    logic              sel;
    logic              rx_valid;
    logic [7:0]        rx_byte;
    logic [7:0]        tx_byte;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [MEM_AW-1:0] mem_raddr;
    logic [7:0]        rd_data;
    logic              wel;
    logic              aai;
    phase_t            phase;
    logic [MEM_AW-1:0] cur_addr;

    spif_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .tx_byte  (tx_byte),
        .sel      (sel),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .miso     (spi_miso)
    );

    spif_ctrl #(.AW(MEM_AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .addr4_en  (addr4_en),
        .rd_data   (rd_data),
        .tx_byte   (tx_byte),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .err_pulse (err_pulse),
        .wel       (wel),
        .aai       (aai),
        .phase     (phase),
        .cur_addr  (cur_addr)
    );

    spif_array #(.AW(MEM_AW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/spif_aai_checker.sv
// Protocol properties for the flash slave, bound onto the top level.
module spif_aai_checker
    import spif_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic [7:0]    rx_byte,
    input phase_t        phase,
    input logic          wel,
    input logic          aai,
    input logic          err_pulse,
    input logic [AW-1:0] cur_addr
);
    logic opcode_seen;
    assign opcode_seen = rx_valid && (phase == PH_IDLE);

    // R4
    seq_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_seen && !wel && rx_byte == OP_SEQ) |=> (err_pulse && !aai && !wel));

    // R5
    seq_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aai |-> wel);

    // R6
    seq_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_seen && aai && rx_byte == OP_SEQ) |=> (phase == PH_PROG && $stable(cur_addr)));

    // R7
    seq_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_seen && aai && rx_byte != OP_SEQ && rx_byte != OP_WRDI && rx_byte != OP_RDSR)
        |=> (err_pulse && aai && $stable(wel)));

    // R8
    wrdi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_seen && !aai && rx_byte == OP_WRDI) |=> (!wel && !aai));

    // R10
    wrap_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && phase == PH_PROG && aai && (&cur_addr)) |=> (!aai && !wel && cur_addr == '0));

    // R12
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);
endmodule

bind spif_aai_slave spif_aai_checker #(.AW(MEM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .phase     (phase),
    .wel       (wel),
    .aai       (aai),
    .err_pulse (err_pulse),
    .cur_addr  (cur_addr)
);

// File: tb/spif_aai_slave_test.sv
module spif_aai_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr4_en = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    wire  miso;
    wire  err;

    integer vectors = 0;
    integer fails = 0;
    integer err_cnt = 0;
    integer err_snap;
    logic [7:0] exp_mem [64];
    logic       m_wel = 1'b0;
    logic       m_aai = 1'b0;
    logic [5:0] m_ptr = '0;
    logic [7:0] dummy;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    spif_aai_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr4_en  (addr4_en),
        .spi_sclk  (sclk),
        .spi_cs_n  (cs_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .err_pulse (err)
    );

    always @(posedge clk) if (err) err_cnt <= err_cnt + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            #30;
            rx[i] = miso;
            sclk = 1'b1;
            #30;
            sclk = 1'b0;
        end
    endtask

    task automatic open_cmd();
        cs_n = 1'b0;
        #30;
    endtask

    task automatic close_cmd();
        #30;
        cs_n = 1'b1;
        #60;
    endtask

    task automatic single(input logic [7:0] op);
        logic [7:0] d;
        open_cmd();
        xfer(op, d);
        close_cmd();
    endtask

    task automatic send_addr(input logic [31:0] a);
        logic [7:0] d;
        if (addr4_en) xfer(a[31:24], d);
        xfer(a[23:16], d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
    endtask

    task automatic status_chk(input string req, input logic [7:0] exp);
        logic [7:0] a;
        logic [7:0] b;
        open_cmd();
        xfer(8'h05, a);
        xfer(8'h00, a);
        xfer(8'h00, b);
        close_cmd();
        check(req, a, exp);
        check(req, b, exp);
    endtask

    task automatic read_chk(input string req, input logic [31:0] a, input int n);
        logic [7:0] d;
        open_cmd();
        xfer(8'h03, d);
        send_addr(a);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, d);
            check(req, d, exp_mem[6'(a[5:0] + 6'(k))]);
        end
        close_cmd();
    endtask

    task automatic pgm(input logic [7:0] b);
        logic [7:0] d;
        xfer(b, d);
        if (m_wel) exp_mem[m_ptr] = exp_mem[m_ptr] & b;
        m_ptr = m_ptr + 6'd1;
        if (m_aai && m_ptr == 6'd0) begin
            m_wel = 1'b0;
            m_aai = 1'b0;
        end
    endtask

    task automatic seq_first(input logic [31:0] a);
        logic [7:0] d;
        xfer(8'hAD, d);
        send_addr(a);
        m_aai = 1'b1;
        m_ptr = {a[5:1], 1'b0};
    endtask

    initial begin
        #900000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got %h expected %h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) exp_mem[i] = 8'hFF;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state of status and whole array
        status_chk("R1", 8'h00);
        read_chk("R1", 32'h0, 64);

        // R4: sequence opcode with latch clear
        err_snap = err_cnt;
        single(8'hAD);
        check("R4", err_cnt - err_snap, 1);
        status_chk("R4", 8'h00);

        // R2: write enable and repeated status
        single(8'h06);
        m_wel = 1'b1;
        status_chk("R2", 8'h02);

        // R5: first sequence opcode, odd address aligned down
        err_snap = err_cnt;
        open_cmd();
        seq_first(32'h11);
        pgm(8'hA5);
        pgm(8'h3C);
        close_cmd();
        check("R5", err_cnt - err_snap, 0);
        status_chk("R9", 8'h42);

        // R6: continuation without address
        open_cmd();
        xfer(8'hAD, dummy);
        pgm(8'h0F);
        pgm(8'hF0);
        close_cmd();
        status_chk("R9", 8'h42);

        // R7: illegal opcodes during the sequence
        err_snap = err_cnt;
        open_cmd();
        xfer(8'h03, dummy);
        xfer(8'h00, dummy);
        xfer(8'h00, dummy);
        xfer(8'h00, dummy);
        xfer(8'h00, dummy);
        close_cmd();
        single(8'h06);
        check("R7", err_cnt - err_snap, 2);
        status_chk("R7", 8'h42);

        // R8: write disable ends the sequence
        single(8'h04);
        m_wel = 1'b0;
        m_aai = 1'b0;
        status_chk("R8", 8'h00);
        read_chk("R5", 32'h10, 1);
        check("R5", exp_mem[16], 8'hA5);
        check("R6", exp_mem[19], 8'hF0);
        read_chk("R6", 32'h0E, 8);

        // R10: AND programming over existing data
        single(8'h06);
        m_wel = 1'b1;
        open_cmd();
        seq_first(32'h10);
        pgm(8'h5A);
        pgm(8'hFF);
        close_cmd();
        single(8'h04);
        m_wel = 1'b0;
        m_aai = 1'b0;
        check("R10", exp_mem[16], 8'h00);
        read_chk("R10", 32'h10, 2);

        // R10/R11: wrap at top of array aborts, trailing byte rejected
        single(8'h06);
        m_wel = 1'b1;
        err_snap = err_cnt;
        open_cmd();
        seq_first(32'h3D);
        pgm(8'h11);
        pgm(8'h22);
        pgm(8'h33);
        pgm(8'h44);
        pgm(8'h55);
        close_cmd();
        check("R11", err_cnt - err_snap, 1);
        status_chk("R10", 8'h00);
        check("R11", exp_mem[0], 8'hFF);
        read_chk("R3", 32'h3C, 6);

        // R12: undefined opcodes
        err_snap = err_cnt;
        single(8'h9F);
        single(8'hFF);
        check("R12", err_cnt - err_snap, 2);

        // R13: chip select aborts a half-sent read
        open_cmd();
        xfer(8'h03, dummy);
        xfer(8'h00, dummy);
        close_cmd();
        single(8'h06);
        status_chk("R13", 8'h02);
        single(8'h04);

        // R5: four-byte address mode, upper bytes fold modulo array size
        addr4_en = 1'b1;
        single(8'h06);
        m_wel = 1'b1;
        open_cmd();
        seq_first(32'h00000021);
        pgm(8'hC3);
        pgm(8'h81);
        close_cmd();
        status_chk("R9", 8'h42);
        single(8'h04);
        m_wel = 1'b0;
        m_aai = 1'b0;
        check("R5", exp_mem[32], 8'hC3);
        read_chk("R5", 32'h12000020, 2);
        addr4_en = 1'b0;

        // R3/R10: final sweep of the whole array
        read_chk("R10", 32'h0, 64);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule